// File: doc/BRIEF.md
# Two-Stage Watchdog Countdown Engine

This block counts down from a programmable timeout on a 33 MHz reference clock and expires in two steps. The first expiry raises a one-cycle interrupt pulse. The interrupt kind is chosen by a two-bit code and may be a normal interrupt request, a system-management interrupt or nothing. After that pulse the block loads the second timeout at once and keeps counting. When the second timeout runs out, the block can pulse a system reset and set a sticky flag that records the event. In free-run mode it then starts again from the first stage.

Software keeps the block alive with a keepalive pulse, which sends it back to the start of stage one. A lock bit can be set in the control write. From then until the next reset, the enable, free-run and lock settings are frozen, so a program that has gone astray cannot turn the watchdog off. Bus decoding, any unlock handshake and the interrupt controller all sit outside this block. The block takes plain write strobes and gives back pulses.

Top module: `wdog2_core`

## Requirements
- R1: After reset the block is disabled and shows stage one (`stage`=0), with all three pulse outputs low. The interrupt code is 0 (interrupt request), reboot is enabled, slow scale is selected and both preload registers hold all ones. Enabling with no further setup therefore gives an interrupt request after 2^SLOW_SHIFT*(2^PRELOAD_W-1) cycles, and then a reset pulse after the same interval again.
- R2: Each stage lasts exactly `preload << SLOW_SHIFT` cycles when `mode_fast`=0 and `preload << FAST_SHIFT` cycles when `mode_fast`=1, counted from the edge that loads the stage. A preload of zero gives a stage of one cycle.
- R3: When stage one expires, `stage` becomes 1 and the stage-two preload is loaded. In the same cycle a one-cycle pulse is issued according to `mode_int`: code 0 pulses `irq_pulse`, code 2 pulses `smi_pulse`, and codes 1 and 3 pulse neither.
- R4: When stage two expires with reboot enabled (`mode_noreboot`=0, an active-low enable), `reset_pulse` is high for one cycle and `prev_reset` is set in the same cycle. With `mode_noreboot`=1 neither happens.
- R5: When free-run is set, a stage-two expiry returns `stage` to 0 and stage one counts again. Without free-run the block holds `stage`=1 and produces no further pulses.
- R6: A control write that takes enable from 0 to 1 starts stage one. A control write with enable 0 stops counting, returns `stage` to 0 and suppresses all pulses.
- R7: Once a control write has set the lock bit, later control writes have no effect on enable, free-run or lock until `rst` is applied.
- R8: A keepalive pulse while enabled reloads the stage-one preload and returns `stage` to 0 from either stage. While disabled it has no effect.
- R9: A keepalive in the same cycle as an expiry wins. No interrupt or reset pulse is issued, and stage one restarts in full from that edge.
- R10: A synchronous `rst` clears lock, enable and free-run, returns `stage` to 0, sets the interrupt code to 0, enables reboot and restores both preloads to all ones.
- R11: `prev_reset` is not changed by `rst`. It is cleared only by `flag_clr`, and if a set and a clear fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 33 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Strobe for the enable, lock and free-run fields |
| cfg_enable | input | 1 | Enable value for the control write |
| cfg_lock | input | 1 | Lock value for the control write |
| cfg_freerun | input | 1 | Free-run value for the control write |
| mode_wr | input | 1 | Strobe for the mode fields |
| mode_noreboot | input | 1 | 1 disables the reset pulse (active-low reboot enable) |
| mode_fast | input | 1 | 1 selects the fast scale |
| mode_int | input | 2 | Stage-one interrupt code: 0 request, 2 system-management, 1/3 none |
| pre1_wr | input | 1 | Writes `pre_data` into the stage-one preload |
| pre2_wr | input | 1 | Writes `pre_data` into the stage-two preload |
| pre_data | input | PRELOAD_W | Preload write data |
| kick | input | 1 | Keepalive pulse |
| flag_clr | input | 1 | Clears the sticky previous-reset flag |
| irq_pulse | output | 1 | One-cycle interrupt request at stage-one expiry |
| smi_pulse | output | 1 | One-cycle system-management interrupt at stage-one expiry |
| reset_pulse | output | 1 | One-cycle system reset at stage-two expiry |
| prev_reset | output | 1 | Sticky flag recording that a reset pulse was issued |
| stage | output | 1 | Current stage: 0 for one, 1 for two |

## Verification
The cases that are hardest to reach from the ports are those that fall on the exact expiry edge. One is a keepalive landing in the very cycle the count reaches zero. The other is the combined stage-two event, where a reset pulse and a free-run restart happen on the same edge. The bench records the clock index of every write. It then drives the keepalive in the negative half-cycle just before the computed expiry edge, so it is sampled on that edge. The bench also sweeps preload values, both scales, all four interrupt codes and the reboot and free-run combinations on a narrow configuration, so that each sweep point runs to its final expiry within a few thousand cycles.

// File: rtl/wdog2_pkg.sv
package wdog2_pkg;

  typedef enum logic [1:0] {
    INT_IRQ   = 2'd0,
    INT_NONE1 = 2'd1,
    INT_SMI   = 2'd2,
    INT_NONE  = 2'd3
  } wd_int_e;

  typedef enum logic {
    STG_ONE = 1'b0,
    STG_TWO = 1'b1
  } wd_stage_e;

endpackage

// File: rtl/wdog2_ctrl.sv
module wdog2_ctrl
  import wdog2_pkg::*;
#(
  parameter int PRELOAD_W = 20,
  parameter logic [PRELOAD_W-1:0] PRELOAD_RST = '1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_wr,
  input  logic                 cfg_enable,
  input  logic                 cfg_lock,
  input  logic                 cfg_freerun,
  input  logic                 mode_wr,
  input  logic                 mode_noreboot,
  input  logic                 mode_fast,
  input  logic [1:0]           mode_int,
  input  logic                 pre1_wr,
  input  logic                 pre2_wr,
  input  logic [PRELOAD_W-1:0] pre_data,
  output logic                 en_q,
  output logic                 free_q,
  output logic                 reboot_en_q,
  output logic                 fast_q,
  output wd_int_e              int_q,
  output logic [PRELOAD_W-1:0] pre1_q,
  output logic [PRELOAD_W-1:0] pre2_q,
  output logic                 start_req,
  output logic                 stop_req
);

  logic lock_q;
  logic wr_ok;

  assign wr_ok     = cfg_wr & ~lock_q;
  assign start_req = wr_ok & cfg_enable & ~en_q;
  assign stop_req  = wr_ok & ~cfg_enable;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= 1'b0;
      en_q   <= 1'b0;
      free_q <= 1'b0;
    end else if (wr_ok) begin
      lock_q <= cfg_lock;
      en_q   <= cfg_enable;
      free_q <= cfg_freerun;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reboot_en_q <= 1'b1;
      fast_q      <= 1'b0;
      int_q       <= INT_IRQ;
    end else if (mode_wr) begin
      reboot_en_q <= ~mode_noreboot;
      fast_q      <= mode_fast;
      int_q       <= wd_int_e'(mode_int);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre1_q <= PRELOAD_RST;
      pre2_q <= PRELOAD_RST;
    end else begin
      if (pre1_wr) pre1_q <= pre_data;
      if (pre2_wr) pre2_q <= pre_data;
    end
  end

  // R7
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> lock_q);

  // R7
  lock_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> ($stable(en_q) && $stable(free_q)));

endmodule

// File: rtl/wdog2_timebase.sv
module wdog2_timebase #(
  parameter int PRELOAD_W  = 20,
  parameter int SLOW_SHIFT = 15,
  parameter int FAST_SHIFT = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic                 run,
  input  logic                 fast,
  input  logic [PRELOAD_W-1:0] pre,
  output logic                 zero_o
);

  localparam int SH_MAX = (SLOW_SHIFT > FAST_SHIFT) ? SLOW_SHIFT : FAST_SHIFT;
  localparam int CW     = PRELOAD_W + SH_MAX;

  logic [CW-1:0] ext;
  logic [CW-1:0] span;
  logic [CW-1:0] load_val;
  logic [CW-1:0] cnt_q;

  always_comb begin
    ext      = CW'(pre);
    span     = fast ? (ext << FAST_SHIFT) : (ext << SLOW_SHIFT);
    load_val = (span == '0) ? '0 : span - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                     cnt_q <= '0;
    else if (load)               cnt_q <= load_val;
    else if (run && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/wdog2_seq.sv
module wdog2_seq
  import wdog2_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      en_i,
  input  logic      start_i,
  input  logic      stop_i,
  input  logic      kick_i,
  input  logic      zero_i,
  input  logic      free_i,
  input  logic      reboot_en_i,
  input  wd_int_e   int_i,
  input  logic      flag_clr_i,
  output logic      load_o,
  output logic      sel_two_o,
  output logic      run_o,
  output wd_stage_e stage_o,
  output logic      irq_o,
  output logic      smi_o,
  output logic      rstp_o,
  output logic      flag_o
);

  wd_stage_e stage_q, stage_d;
  logic run_q, run_d;
  logic irq_q, irq_d, smi_q, smi_d, rstp_q, rstp_d;
  logic flag_q;
  logic kick_ok, expire;

  assign kick_ok = kick_i & en_i & ~stop_i;
  assign expire  = run_q & zero_i & ~kick_ok & ~stop_i & ~start_i;

  always_comb begin
    stage_d   = stage_q;
    run_d     = run_q;
    load_o    = 1'b0;
    sel_two_o = 1'b0;
    irq_d     = 1'b0;
    smi_d     = 1'b0;
    rstp_d    = 1'b0;
    if (start_i || kick_ok) begin
      load_o  = 1'b1;
      run_d   = 1'b1;
      stage_d = STG_ONE;
    end else if (stop_i) begin
      run_d   = 1'b0;
      stage_d = STG_ONE;
    end else if (expire) begin
      if (stage_q == STG_ONE) begin
        load_o    = 1'b1;
        sel_two_o = 1'b1;
        stage_d   = STG_TWO;
        irq_d     = (int_i == INT_IRQ);
        smi_d     = (int_i == INT_SMI);
      end else begin
        rstp_d = reboot_en_i;
        if (free_i) begin
          load_o  = 1'b1;
          stage_d = STG_ONE;
        end else begin
          run_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= STG_ONE;
      run_q   <= 1'b0;
      irq_q   <= 1'b0;
      smi_q   <= 1'b0;
      rstp_q  <= 1'b0;
    end else begin
      stage_q <= stage_d;
      run_q   <= run_d;
      irq_q   <= irq_d;
      smi_q   <= smi_d;
      rstp_q  <= rstp_d;
    end
  end

  // sticky flag survives rst on purpose; set has priority over clear
  always_ff @(posedge clk) begin
    if (rstp_d)          flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end

  assign run_o   = run_q;
  assign stage_o = stage_q;
  assign irq_o   = irq_q;
  assign smi_o   = smi_q;
  assign rstp_o  = rstp_q;
  assign flag_o  = flag_q;

  // R3
  irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q);

  // R3
  stage_adv_chk: assert property (@(posedge clk) disable iff (rst)
    (stage_q == STG_TWO && $past(stage_q) == STG_ONE) |-> $past(zero_i && run_q));

  // R4
  reboot_flag_chk: assert property (@(posedge clk) disable iff (rst)
    rstp_q |-> flag_q);

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !(irq_q || smi_q || rstp_q));

  // R9
  kick_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (kick_i && en_i && !stop_i && !start_i) |=>
      (!irq_q && !smi_q && !rstp_q && stage_q == STG_ONE));

endmodule

// File: rtl/wdog2_core.sv
module wdog2_core
  import wdog2_pkg::*;
#(
  parameter int PRELOAD_W  = 20,
  parameter int SLOW_SHIFT = 15,
  parameter int FAST_SHIFT = 5,
  parameter logic [PRELOAD_W-1:0] PRELOAD_RST = '1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_wr,
  input  logic                 cfg_enable,
  input  logic                 cfg_lock,
  input  logic                 cfg_freerun,
  input  logic                 mode_wr,
  input  logic                 mode_noreboot,
  input  logic                 mode_fast,
  input  logic [1:0]           mode_int,
  input  logic                 pre1_wr,
  input  logic                 pre2_wr,
  input  logic [PRELOAD_W-1:0] pre_data,
  input  logic                 kick,
  input  logic                 flag_clr,
  output logic                 irq_pulse,
  output logic                 smi_pulse,
  output logic                 reset_pulse,
  output logic                 prev_reset,
  output logic                 stage
);

  logic en_q, free_q, reboot_en_q, fast_q;
  wd_int_e int_q;
  logic [PRELOAD_W-1:0] pre1_q, pre2_q, pre_sel;
  logic start_req, stop_req;
  logic load, sel_two, run, zero;
  wd_stage_e stage_s;

  wdog2_ctrl #(.PRELOAD_W(PRELOAD_W), .PRELOAD_RST(PRELOAD_RST)) ctrl_i (
    .clk(clk), .rst(rst),
    .cfg_wr(cfg_wr), .cfg_enable(cfg_enable), .cfg_lock(cfg_lock),
    .cfg_freerun(cfg_freerun),
    .mode_wr(mode_wr), .mode_noreboot(mode_noreboot), .mode_fast(mode_fast),
    .mode_int(mode_int),
    .pre1_wr(pre1_wr), .pre2_wr(pre2_wr), .pre_data(pre_data),
    .en_q(en_q), .free_q(free_q), .reboot_en_q(reboot_en_q), .fast_q(fast_q),
    .int_q(int_q), .pre1_q(pre1_q), .pre2_q(pre2_q),
    .start_req(start_req), .stop_req(stop_req)
  );

  assign pre_sel = sel_two ? pre2_q : pre1_q;

  wdog2_timebase #(.PRELOAD_W(PRELOAD_W), .SLOW_SHIFT(SLOW_SHIFT),
                   .FAST_SHIFT(FAST_SHIFT)) tb_i (
    .clk(clk), .rst(rst), .load(load), .run(run), .fast(fast_q),
    .pre(pre_sel), .zero_o(zero)
  );

  wdog2_seq seq_i (
    .clk(clk), .rst(rst), .en_i(en_q), .start_i(start_req), .stop_i(stop_req),
    .kick_i(kick), .zero_i(zero), .free_i(free_q), .reboot_en_i(reboot_en_q),
    .int_i(int_q), .flag_clr_i(flag_clr),
    .load_o(load), .sel_two_o(sel_two), .run_o(run), .stage_o(stage_s),
    .irq_o(irq_pulse), .smi_o(smi_pulse), .rstp_o(reset_pulse),
    .flag_o(prev_reset)
  );

  assign stage = stage_s;

endmodule

// File: tb/wdog2_core_tb.sv
module wdog2_core_tb_top;

  localparam int PW = 6;
  localparam int SS = 4;
  localparam int FS = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 0, cfg_enable = 0, cfg_lock = 0, cfg_freerun = 0;
  logic mode_wr = 0, mode_noreboot = 0, mode_fast = 0;
  logic [1:0] mode_int = 2'd0;
  logic pre1_wr = 0, pre2_wr = 0;
  logic [PW-1:0] pre_data = '0;
  logic kick = 0, flag_clr = 0;
  logic irq_pulse, smi_pulse, reset_pulse, prev_reset, stage;

  int cyc = 0;
  int checks = 0;
  int errs = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog2_core #(.PRELOAD_W(PW), .SLOW_SHIFT(SS), .FAST_SHIFT(FS)) dut_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_enable(cfg_enable),
    .cfg_lock(cfg_lock), .cfg_freerun(cfg_freerun), .mode_wr(mode_wr),
    .mode_noreboot(mode_noreboot), .mode_fast(mode_fast), .mode_int(mode_int),
    .pre1_wr(pre1_wr), .pre2_wr(pre2_wr), .pre_data(pre_data), .kick(kick),
    .flag_clr(flag_clr), .irq_pulse(irq_pulse), .smi_pulse(smi_pulse),
    .reset_pulse(reset_pulse), .prev_reset(prev_reset), .stage(stage)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int tmo(input int p, input bit fast);
    int t;
    t = p << (fast ? FS : SS);
    return (t == 0) ? 1 : t;
  endfunction

  task automatic do_reset(input bit clr);
    rst = 1'b1; flag_clr = clr;
    repeat (2) @(negedge clk);
    rst = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic wr_cfg(input bit en, input bit lk, input bit fr, output int c);
    cfg_enable = en; cfg_lock = lk; cfg_freerun = fr; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    c = cyc;
  endtask

  task automatic wr_mode(input bit nrb, input bit fast, input logic [1:0] ty);
    mode_noreboot = nrb; mode_fast = fast; mode_int = ty; mode_wr = 1'b1;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic wr_pre(input int p1, input int p2);
    pre_data = PW'(p1); pre1_wr = 1'b1;
    @(negedge clk);
    pre1_wr = 1'b0; pre_data = PW'(p2); pre2_wr = 1'b1;
    @(negedge clk);
    pre2_wr = 1'b0;
  endtask

  // drive kick so that it is sampled on edge number tgt
  task automatic kick_at(input int tgt);
    while (cyc < tgt - 1) @(negedge clk);
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
  endtask

  task automatic wait_evt(input int lim, output int ev, output logic gi,
                          output logic gs, output logic gr, output logic st);
    logic s0;
    s0 = stage; ev = -1; gi = 0; gs = 0; gr = 0;
    for (int n = 0; n <= lim; n++) begin
      @(negedge clk);
      if (irq_pulse || smi_pulse || reset_pulse || stage != s0) begin
        ev = cyc; gi = irq_pulse; gs = smi_pulse; gr = reset_pulse;
        break;
      end
    end
    st = stage;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    int c0, ev, t1, t2, p1, p2;
    logic gi, gs, gr, st;
    bit rbd, fr;

    do_reset(1'b1);
    // R1 reset state
    chk(stage == 1'b0, "R1", "stage after reset", stage, 0);
    chk(!irq_pulse && !smi_pulse && !reset_pulse, "R1", "pulses after reset",
        irq_pulse + smi_pulse + reset_pulse, 0);
    chk(prev_reset == 1'b0, "R11", "flag after clear", prev_reset, 0);

    // R10: scramble settings, reset, then defaults must apply
    wr_mode(1'b1, 1'b1, 2'd2);
    wr_pre(1, 1);
    do_reset(1'b0);
    wr_cfg(1'b1, 1'b0, 1'b0, c0);
    t1 = tmo((1 << PW) - 1, 1'b0);
    wait_evt(t1 + 10, ev, gi, gs, gr, st);
    chk(ev - c0 == t1, "R10", "default stage-one length", ev - c0, t1);
    chk(gi && !gs, "R1", "default code gives irq", gi, 1);
    c0 = ev;
    wait_evt(t1 + 10, ev, gi, gs, gr, st);
    chk(ev - c0 == t1, "R1", "default stage-two length", ev - c0, t1);
    chk(gr == 1'b1, "R10", "reboot enabled by default", gr, 1);
    chk(prev_reset == 1'b1, "R4", "flag set by reset pulse", prev_reset, 1);
    // R11: rst keeps the flag, flag_clr clears it
    do_reset(1'b0);
    chk(prev_reset == 1'b1, "R11", "flag kept over rst", prev_reset, 1);
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    chk(prev_reset == 1'b0, "R11", "flag cleared", prev_reset, 0);

    // sweep: preload, scale, interrupt code, reboot, free-run
    for (int pi = 0; pi < 8; pi++) begin
      for (int fs = 0; fs < 2; fs++) begin
        for (int ty = 0; ty < 4; ty++) begin
          p1 = (pi * 9) % 64;
          p2 = (p1 * 5 + 7) % 64;
          rbd = pi[0] ^ fs[0];
          fr = rbd | ty[0];
          t1 = tmo(p1, fs[0]);
          t2 = tmo(p2, fs[0]);
          do_reset(1'b1);
          wr_mode(rbd, fs[0], 2'(ty));
          wr_pre(p1, p2);
          wr_cfg(1'b1, 1'b0, fr, c0);
          wait_evt(t1 + 4, ev, gi, gs, gr, st);
          chk(ev - c0 == t1, "R2", "stage-one length", ev - c0, t1);
          chk(st == 1'b1, "R3", "stage two entered", st, 1);
          chk(gi == (ty == 0), "R3", "irq per code", gi, int'(ty == 0));
          chk(gs == (ty == 2), "R3", "smi per code", gs, int'(ty == 2));
          c0 = ev;
          wait_evt(t2 + 4, ev, gi, gs, gr, st);
          chk(ev - c0 == t2, "R2", "stage-two length", ev - c0, t2);
          chk(gr == !rbd, "R4", "reset pulse per reboot bit", gr, int'(!rbd));
          chk(prev_reset == !rbd, "R4", "sticky flag", prev_reset, int'(!rbd));
          chk(!gi && !gs, "R3", "no interrupt at stage two", gi + gs, 0);
          c0 = ev;
          if (fr) begin
            chk(st == 1'b0, "R5", "free-run back to stage one", st, 0);
            wait_evt(t1 + 4, ev, gi, gs, gr, st);
            chk(ev - c0 == t1, "R5", "free-run restart length", ev - c0, t1);
          end else begin
            wait_evt(t1 + t2 + 4, ev, gi, gs, gr, st);
            chk(ev == -1, "R5", "halted after final expiry", ev, -1);
            chk(st == 1'b1, "R5", "holds stage two", st, 1);
          end
        end
      end
    end

    // R7: lock freezes enable/free-run
    do_reset(1'b1);
    wr_pre(2, 2);
    t1 = tmo(2, 1'b0);
    wr_cfg(1'b1, 1'b1, 1'b0, c0);
    repeat (4) @(negedge clk);
    wr_cfg(1'b0, 1'b0, 1'b1, ev);
    wait_evt(t1 + 4, ev, gi, gs, gr, st);
    chk(ev - c0 == t1, "R7", "disable ignored when locked", ev - c0, t1);
    c0 = ev;
    wait_evt(t1 + 4, ev, gi, gs, gr, st);
    chk(gr == 1'b1, "R7", "still counting to reset", gr, 1);
    c0 = ev;
    wait_evt(2 * t1 + 4, ev, gi, gs, gr, st);
    chk(ev == -1, "R7", "free-run write ignored", ev, -1);
    // R10: lock cleared by rst, so a disable write works
    do_reset(1'b1);
    wr_cfg(1'b1, 1'b0, 1'b0, c0);
    wr_cfg(1'b0, 1'b0, 1'b0, c0);
    wait_evt(2200, ev, gi, gs, gr, st);
    chk(ev == -1, "R10", "lock cleared by reset", ev, -1);

    // R6: stop and restart
    do_reset(1'b1);
    wr_pre(2, 3);
    t1 = tmo(2, 1'b0);
    wr_cfg(1'b1, 1'b0, 1'b0, c0);
    repeat (9) @(negedge clk);
    wr_cfg(1'b0, 1'b0, 1'b0, c0);
    wait_evt(3 * t1, ev, gi, gs, gr, st);
    chk(ev == -1, "R6", "no event after disable", ev, -1);
    chk(stage == 1'b0, "R6", "stage one when stopped", stage, 0);
    wr_cfg(1'b1, 1'b0, 1'b0, c0);
    wait_evt(t1 + 4, ev, gi, gs, gr, st);
    chk(ev - c0 == t1, "R6", "re-enable full stage one", ev - c0, t1);
    // stop from stage two
    wr_cfg(1'b0, 1'b0, 1'b0, c0);
    chk(stage == 1'b0, "R6", "disable in stage two", stage, 0);

    // R8: keepalive in stage one and stage two
    wr_cfg(1'b1, 1'b0, 1'b0, c0);
    kick_at(c0 + 20);
    wait_evt(t1 + 4, ev, gi, gs, gr, st);
    chk(ev - (c0 + 20) == t1, "R8", "kick reloads stage one", ev - c0 - 20, t1);
    c0 = ev;
    kick_at(c0 + 5);
    chk(stage == 1'b0, "R8", "kick leaves stage two", stage, 0);
    wait_evt(t1 + 4, ev, gi, gs, gr, st);
    chk(ev - (c0 + 5) == t1, "R8", "stage one after kick", ev - c0 - 5, t1);
    // kick while disabled
    wr_cfg(1'b0, 1'b0, 1'b0, c0);
    kick_at(c0 + 3);
    wait_evt(3 * t1, ev, gi, gs, gr, st);
    chk(ev == -1 && stage == 1'b0, "R8", "kick ignored while disabled", ev, -1);

    // R9: kick on the exact expiry edge
    wr_cfg(1'b1, 1'b0, 1'b0, c0);
    kick_at(c0 + t1);
    wait_evt(t1 + 4, ev, gi, gs, gr, st);
    chk(ev - c0 == 2 * t1, "R9", "kick beats stage-one expiry", ev - c0, 2 * t1);
    c0 = ev;
    t2 = tmo(3, 1'b0);
    kick_at(c0 + t2);
    chk(reset_pulse == 1'b0 && stage == 1'b0, "R9", "kick beats stage-two expiry",
        reset_pulse, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

endmodule